// File: doc/BRIEF.md
# Warp Divergence Reconvergence Stack

In a core that runs every thread of a warp from one shared program counter, this block handles branches where threads disagree. Each warp owns a small stack. A split request carries the warp's active thread mask, a per-thread taken predicate (with an invert flag) and the PC of the not-taken path. The block answers with the mask to run first and saves what it needs to run the other path and to bring the full mask back later. A join request pops the warp's stack. It answers either with the other path's PC and mask, which is a redirect, or with the restored original mask. A third request kind applies a predicate to the mask, with a fallback mask that is used if no thread would be left.

Each request gets one registered answer in the cycle after it is accepted. Per-warp full and empty flags show how deep each stack is. A sticky error flag records any attempt to push past the stack depth or to pop an empty stack. Warp selection and instruction decode are handled elsewhere.

Top module: `dvg_reconv_stack`

## Requirements
- R1: The `req_op` encodings are 2'b01 split, 2'b10 join, 2'b11 predicate and 2'b00 no operation. `out_valid` is high for exactly the one cycle after each accepted request whose op is not 2'b00. A no-operation request produces no answer and changes no state.
- R2: The effective predicate is `req_mask & (req_pred ^ {T{req_invert}})`. Bit i stands for thread i.
- R3: A split is uniform when the effective predicate equals `req_mask` or is zero. A uniform split answers with mask `req_mask`, PC `req_pc` and redirect 0, and pushes one marker entry. A join that pops the marker answers with the join's own `req_mask`, its `req_pc` and redirect 0.
- R4: A divergent split answers with the effective predicate as the mask, `req_pc` and redirect 0. It pushes the original mask first, then an else entry that holds `req_mask & ~effective` and `req_pc`.
- R5: A join that pops an else entry answers with the saved complement mask, the saved PC and redirect 1.
- R6: A join that pops an original-mask entry answers with the saved mask, the join's `req_pc` and redirect 0.
- R7: A predicate request answers with the effective predicate, or with `req_restore` when the effective predicate is zero. The PC is `req_pc` and redirect is 0. It leaves the stack untouched.
- R8: Each warp has its own stack. A request changes only the stack selected by `req_warp`.
- R9: `stk_empty[w]` is high when warp w's stack holds no entries. `stk_full[w]` is high when it holds `STACK_DEPTH` entries.
- R10: A split that needs more free entries than are left (one for uniform, two for divergent) pushes nothing, answers with `req_mask`, `req_pc` and redirect 0, and sets `err`. A join on an empty stack answers with `req_mask`, `req_pc` and redirect 0, and sets `err`.
- R11: Once set, `err` stays high until reset.
- R12: After a synchronous active-low reset, every stack is empty, and `err` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code (R1) |
| req_warp | input | WID_W | Warp whose stack is addressed |
| req_mask | input | NUM_THREADS | Warp's current active thread mask |
| req_pred | input | NUM_THREADS | Per-thread taken predicate |
| req_invert | input | 1 | Invert the predicate before use |
| req_restore | input | NUM_THREADS | Fallback mask for predicate requests |
| req_pc | input | PC_W | Else PC on split, next PC on join and predicate |
| out_valid | output | 1 | Answer pulse |
| out_mask | output | NUM_THREADS | Thread mask to run next |
| out_pc | output | PC_W | PC that goes with the answer |
| out_redirect | output | 1 | Warp must jump to `out_pc` |
| stk_full | output | NUM_WARPS | Per-warp stack full |
| stk_empty | output | NUM_WARPS | Per-warp stack empty |
| err | output | 1 | Sticky overflow/underflow flag |

## Verification
The assertions check, on every cycle, the one-cycle answer timing, that a split's mask never leaves the incoming mask, that a predicate request with a non-zero fallback never answers with zero threads, that redirects come only from joins, that popping an empty stack sets the error flag, that the error flag is sticky, and that full and empty are never both set. The stack's ordering can only be shown by the bench's scenarios. That means the else path being handed out before the original mask, the return of nested splits in reverse order, the marker pops, the invert flag, the isolation between warps and the refusal of a push into a full stack, all of which need stored values compared across many requests.

// File: rtl/dvg_pkg.sv
// Shared encodings for the divergence stack.
// Assumes: the op and entry codes are fixed two-bit values.
package dvg_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_SPLIT = 2'b01,
        OP_JOIN  = 2'b10,
        OP_PRED  = 2'b11
    } dvg_op_e;

    typedef enum logic [1:0] {
        ENT_NONDIV = 2'b00,
        ENT_ORIG   = 2'b01,
        ENT_ELSE   = 2'b10
    } dvg_kind_e;

endpackage

// File: rtl/dvg_mask_eval.sv
// Combinational predicate evaluation for one request.
// Assumes: mask, pred and restore are bit-aligned per thread.
module dvg_mask_eval #(
    parameter int T = 4
) (
    input  logic [T-1:0] mask,
    input  logic [T-1:0] pred,
    input  logic         invert,
    input  logic [T-1:0] restore,
    output logic [T-1:0] taken,
    output logic [T-1:0] not_taken,
    output logic         uniform,
    output logic [T-1:0] pred_mask
);

    // Apply the optionally inverted predicate to the active threads.
    always_comb begin
        taken     = mask & (pred ^ {T{invert}});
        not_taken = mask & ~taken;
        uniform   = (taken == mask) || (taken == '0);
        pred_mask = (taken == '0) ? restore : taken;
    end

endmodule

// File: rtl/dvg_lane_stack.sv
// One warp's reconvergence stack: pushes one or two entries, pops one.
// Assumes: the caller never pushes past DEPTH or pops when empty.
module dvg_lane_stack
    import dvg_pkg::*;
#(
    parameter int T      = 4,
    parameter int PC_W   = 32,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_one,
    input  logic             push_two,
    input  logic             pop,
    input  dvg_kind_e        lo_kind,
    input  logic [T-1:0]     lo_mask,
    input  logic [PC_W-1:0]  lo_pc,
    input  dvg_kind_e        hi_kind,
    input  logic [T-1:0]     hi_mask,
    input  logic [PC_W-1:0]  hi_pc,
    output dvg_kind_e        top_kind,
    output logic [T-1:0]     top_mask,
    output logic [PC_W-1:0]  top_pc,
    output logic [CNT_W-1:0] free_slots,
    output logic             full,
    output logic             empty
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cnt;
    dvg_kind_e        kind_q [DEPTH];
    logic [T-1:0]     mask_q [DEPTH];
    logic [PC_W-1:0]  pc_q   [DEPTH];
    logic [IDX_W-1:0] idx_lo, idx_hi, idx_top;

    // Slot indices for the next push and for the current top.
    always_comb begin
        idx_lo  = cnt[IDX_W-1:0];
        idx_hi  = idx_lo + IDX_W'(1);
        idx_top = idx_lo - IDX_W'(1);
    end

    // Entry storage; the low entry goes in first, the high entry above it.
    always_ff @(posedge clk) begin
        if (push_one || push_two) begin
            kind_q[idx_lo] <= lo_kind;
            mask_q[idx_lo] <= lo_mask;
            pc_q[idx_lo]   <= lo_pc;
        end
        if (push_two) begin
            kind_q[idx_hi] <= hi_kind;
            mask_q[idx_hi] <= hi_mask;
            pc_q[idx_hi]   <= hi_pc;
        end
    end

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (push_two) cnt <= cnt + CNT_W'(2);
        else if (push_one) cnt <= cnt + CNT_W'(1);
        else if (pop)      cnt <= cnt - CNT_W'(1);
    end

    // Top-of-stack view and occupancy flags.
    always_comb begin
        top_kind   = kind_q[idx_top];
        top_mask   = mask_q[idx_top];
        top_pc     = pc_q[idx_top];
        free_slots = DEPTH_C - cnt;
        full       = (cnt == DEPTH_C);
        empty      = (cnt == '0);
    end

endmodule

// File: rtl/dvg_reconv_stack.sv
// Per-warp divergence/reconvergence stack with registered answers.
// Assumes: at most one request per cycle; req_warp < NUM_WARPS.
module dvg_reconv_stack
    import dvg_pkg::*;
#(
    parameter int NUM_WARPS   = 4,
    parameter int NUM_THREADS = 4,
    parameter int STACK_DEPTH = 4,
    parameter int PC_W        = 32,
    parameter int WID_W       = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [1:0]             req_op,
    input  logic [WID_W-1:0]       req_warp,
    input  logic [NUM_THREADS-1:0] req_mask,
    input  logic [NUM_THREADS-1:0] req_pred,
    input  logic                   req_invert,
    input  logic [NUM_THREADS-1:0] req_restore,
    input  logic [PC_W-1:0]        req_pc,
    output logic                   out_valid,
    output logic [NUM_THREADS-1:0] out_mask,
    output logic [PC_W-1:0]        out_pc,
    output logic                   out_redirect,
    output logic [NUM_WARPS-1:0]   stk_full,
    output logic [NUM_WARPS-1:0]   stk_empty,
    output logic                   err
);

    localparam int T     = NUM_THREADS;
    localparam int CNT_W = $clog2(STACK_DEPTH + 1);

    dvg_op_e          op;
    logic             do_split, do_join, do_pred;
    logic [T-1:0]     taken, not_taken, pred_mask;
    logic             uniform;
    logic             overflow, underflow;
    logic             push_one, push_two, pop;
    dvg_kind_e        lo_kind;

    dvg_kind_e        lane_kind [NUM_WARPS];
    logic [T-1:0]     lane_mask [NUM_WARPS];
    logic [PC_W-1:0]  lane_pc   [NUM_WARPS];
    logic [CNT_W-1:0] lane_free [NUM_WARPS];

    logic [T-1:0]     nxt_mask;
    logic [PC_W-1:0]  nxt_pc;
    logic             nxt_redirect;

    dvg_mask_eval #(.T(T)) u_eval (
        .mask      (req_mask),
        .pred      (req_pred),
        .invert    (req_invert),
        .restore   (req_restore),
        .taken     (taken),
        .not_taken (not_taken),
        .uniform   (uniform),
        .pred_mask (pred_mask)
    );

    // Request decode and stack-capacity checks for the selected warp.
    always_comb begin
        op        = dvg_op_e'(req_op);
        do_split  = req_valid && (op == OP_SPLIT);
        do_join   = req_valid && (op == OP_JOIN);
        do_pred   = req_valid && (op == OP_PRED);
        overflow  = do_split &&
                    (lane_free[req_warp] < (uniform ? CNT_W'(1) : CNT_W'(2)));
        underflow = do_join && stk_empty[req_warp];
        push_one  = do_split && uniform && !overflow;
        push_two  = do_split && !uniform && !overflow;
        pop       = do_join && !underflow;
        lo_kind   = uniform ? ENT_NONDIV : ENT_ORIG;
    end

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_lane
        logic sel;
        assign sel = (req_warp == WID_W'(w));

        dvg_lane_stack #(
            .T     (T),
            .PC_W  (PC_W),
            .DEPTH (STACK_DEPTH),
            .CNT_W (CNT_W)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_one   (push_one && sel),
            .push_two   (push_two && sel),
            .pop        (pop && sel),
            .lo_kind    (lo_kind),
            .lo_mask    (req_mask),
            .lo_pc      (req_pc),
            .hi_kind    (ENT_ELSE),
            .hi_mask    (not_taken),
            .hi_pc      (req_pc),
            .top_kind   (lane_kind[w]),
            .top_mask   (lane_mask[w]),
            .top_pc     (lane_pc[w]),
            .free_slots (lane_free[w]),
            .full       (stk_full[w]),
            .empty      (stk_empty[w])
        );
    end

    // Answer selection per operation and popped entry kind.
    always_comb begin
        nxt_mask     = req_mask;
        nxt_pc       = req_pc;
        nxt_redirect = 1'b0;
        if (do_split && !uniform && !overflow) begin
            nxt_mask = taken;
        end else if (do_pred) begin
            nxt_mask = pred_mask;
        end else if (pop) begin
            case (lane_kind[req_warp])
                ENT_ELSE: begin
                    nxt_mask     = lane_mask[req_warp];
                    nxt_pc       = lane_pc[req_warp];
                    nxt_redirect = 1'b1;
                end
                ENT_ORIG: nxt_mask = lane_mask[req_warp];
                default:  nxt_mask = req_mask;
            endcase
        end
    end

    // Registered answer, valid pulse and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_mask     <= '0;
            out_pc       <= '0;
            out_redirect <= 1'b0;
            err          <= 1'b0;
        end else begin
            out_valid <= req_valid && (op != OP_NONE);
            if (req_valid && (op != OP_NONE)) begin
                out_mask     <= nxt_mask;
                out_pc       <= nxt_pc;
                out_redirect <= nxt_redirect;
            end else begin
                out_redirect <= 1'b0;
            end
            if (overflow || underflow) err <= 1'b1;
        end
    end

endmodule

// File: rtl/dvg_reconv_stack_chk.sv
// Property checker for the divergence stack, bound to its top.
// Assumes: reset is held low during the first clock edge.
module dvg_reconv_stack_chk #(
    parameter int NUM_WARPS   = 4,
    parameter int NUM_THREADS = 4,
    parameter int WID_W       = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic [1:0]             req_op,
    input logic [WID_W-1:0]       req_warp,
    input logic [NUM_THREADS-1:0] req_mask,
    input logic [NUM_THREADS-1:0] req_restore,
    input logic                   out_valid,
    input logic [NUM_THREADS-1:0] out_mask,
    input logic                   out_redirect,
    input logic [NUM_WARPS-1:0]   stk_full,
    input logic [NUM_WARPS-1:0]   stk_empty,
    input logic                   err
);

    a_r1_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != 2'b00) |=> out_valid);

    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_op != 2'b00) |=> !out_valid);

    a_r4_split_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b01) |=> ((out_mask & ~$past(req_mask)) == '0));

    a_r5_redirect_join_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_op == 2'b10) |=> !out_redirect);

    a_r7_pred_never_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b11 && req_restore != '0) |=> (out_mask != '0));

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        ((stk_full & stk_empty) == '0));

    a_r10_underflow_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b10 && stk_empty[req_warp]) |=> err);

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

endmodule

bind dvg_reconv_stack dvg_reconv_stack_chk #(
    .NUM_WARPS   (NUM_WARPS),
    .NUM_THREADS (NUM_THREADS),
    .WID_W       (WID_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_warp     (req_warp),
    .req_mask     (req_mask),
    .req_restore  (req_restore),
    .out_valid    (out_valid),
    .out_mask     (out_mask),
    .out_redirect (out_redirect),
    .stk_full     (stk_full),
    .stk_empty    (stk_empty),
    .err          (err)
);

// File: tb/test_dvg_reconv_stack.sv
// Scoreboard bench: the driver queues expected answers, the monitor compares them.
module test_dvg_reconv_stack;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [1:0]  req_warp = '0;
    logic [3:0]  req_mask = '0, req_pred = '0, req_restore = '0;
    logic        req_invert = 1'b0;
    logic [31:0] req_pc = '0;
    logic        out_valid, out_redirect, err;
    logic [3:0]  out_mask, stk_full, stk_empty;
    logic [31:0] out_pc;

    int total = 0;
    int bad   = 0;

    logic [3:0]  q_mask [$];
    logic [31:0] q_pc   [$];
    logic        q_red  [$];
    string       q_tag  [$];

    always #5 clk = ~clk;

    dvg_reconv_stack i_dvg_reconv_stack (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_op (req_op),
        .req_warp (req_warp), .req_mask (req_mask), .req_pred (req_pred),
        .req_invert (req_invert), .req_restore (req_restore), .req_pc (req_pc),
        .out_valid (out_valid), .out_mask (out_mask), .out_pc (out_pc),
        .out_redirect (out_redirect), .stk_full (stk_full),
        .stk_empty (stk_empty), .err (err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input int w, input logic [3:0] m,
                         input logic [3:0] p, input logic inv, input logic [3:0] rs,
                         input logic [31:0] pc, input logic [3:0] em,
                         input logic [31:0] epc, input logic er, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_warp = 2'(w); req_mask = m;
        req_pred = p; req_invert = inv; req_restore = rs; req_pc = pc;
        if (op != 2'b00) begin
            q_mask.push_back(em); q_pc.push_back(epc);
            q_red.push_back(er);  q_tag.push_back(tag);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'b00;
    endtask

    // Monitor: compare each answer against the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_mask.size() == 0) begin
                check("R1 unexpected answer", 64'(out_mask), 64'hx);
            end else begin
                check(q_tag[0], {27'd0, out_redirect, out_pc, out_mask},
                      {27'd0, q_red[0], q_pc[0], q_mask[0]});
                void'(q_mask.pop_front()); void'(q_pc.pop_front());
                void'(q_red.pop_front());  void'(q_tag.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 out_valid", 64'(out_valid), 64'd0);
        check("R12 empty", 64'(stk_empty), 64'hF);
        check("R12 err", 64'(err), 64'd0);

        // R4 divergent split, then nested split filling warp 0 (R9)
        issue(2'b01, 0, 4'b1111, 4'b0011, 0, 4'h0, 32'h100, 4'b0011, 32'h100, 0, "R4 split outer");
        issue(2'b01, 0, 4'b0011, 4'b0001, 0, 4'h0, 32'h200, 4'b0001, 32'h200, 0, "R4 split nested");
        idle();
        check("R9 full w0", 64'(stk_full), 64'b0001);
        check("R9 empty others", 64'(stk_empty), 64'b1110);

        // R7 predicate falls back to restore; warp 1 stack stays empty (R8)
        issue(2'b11, 1, 4'b1111, 4'b0000, 0, 4'b1010, 32'h50, 4'b1010, 32'h50, 0, "R7 pred restore");
        idle();
        check("R7 stack untouched", 64'(stk_empty[1]), 64'd1);

        // R3 uniform split pushes a marker
        issue(2'b01, 1, 4'b0110, 4'b1111, 0, 4'h0, 32'h300, 4'b0110, 32'h300, 0, "R3 uniform split");
        idle();
        check("R3 marker pushed", 64'({stk_full[1], stk_empty[1]}), 64'b00);

        // R10 push into a full stack is refused and flags error
        issue(2'b01, 0, 4'b0001, 4'b0000, 0, 4'h0, 32'h400, 4'b0001, 32'h400, 0, "R10 overflow split");
        idle();
        check("R10 err on overflow", 64'(err), 64'd1);
        check("R10 w0 still full", 64'(stk_full[0]), 64'd1);

        // R5/R6 pops in reverse order of the pushes
        issue(2'b10, 0, 4'b0001, 4'h0, 0, 4'h0, 32'h210, 4'b0010, 32'h200, 1, "R5 join inner else");
        issue(2'b10, 0, 4'b0010, 4'h0, 0, 4'h0, 32'h220, 4'b0011, 32'h220, 0, "R6 join inner orig");
        issue(2'b10, 0, 4'b0011, 4'h0, 0, 4'h0, 32'h230, 4'b1100, 32'h100, 1, "R5 join outer else");
        issue(2'b10, 0, 4'b1100, 4'h0, 0, 4'h0, 32'h240, 4'b1111, 32'h240, 0, "R6 join outer orig");
        idle();
        check("R9 w0 empty again", 64'(stk_empty[0]), 64'd1);

        // R3 marker pop; R10 underflow; R11 sticky
        issue(2'b10, 1, 4'b0110, 4'h0, 0, 4'h0, 32'h310, 4'b0110, 32'h310, 0, "R3 join marker");
        issue(2'b10, 0, 4'b1111, 4'h0, 0, 4'h0, 32'h500, 4'b1111, 32'h500, 0, "R10 underflow join");
        idle();
        check("R11 err sticky", 64'(err), 64'd1);
        check("R8 w1 empty", 64'(stk_empty[1]), 64'd1);

        // R2 inverted predicate; R7 normal predicate; R3 all-not-taken split
        issue(2'b01, 2, 4'b1111, 4'b0011, 1, 4'h0, 32'h600, 4'b1100, 32'h600, 0, "R2 inverted split");
        issue(2'b10, 2, 4'b1100, 4'h0, 0, 4'h0, 32'h610, 4'b0011, 32'h600, 1, "R2 inverted else");
        issue(2'b11, 3, 4'b1110, 4'b0111, 0, 4'b1111, 32'h650, 4'b0110, 32'h650, 0, "R7 pred applied");
        issue(2'b01, 3, 4'b1010, 4'b0101, 0, 4'h0, 32'h680, 4'b1010, 32'h680, 0, "R3 none taken split");
        idle();
        check("R3 marker w3", 64'(stk_empty[3]), 64'd0);
        issue(2'b10, 3, 4'b1010, 4'h0, 0, 4'h0, 32'h700, 4'b1010, 32'h700, 0, "R3 join marker w3");

        // R1 no-operation gives no answer
        issue(2'b00, 3, 4'b1111, 4'h0, 0, 4'h0, 32'h800, 4'h0, 32'h0, 0, "R1 nop");
        idle();
        check("R1 no answer for nop", 64'(out_valid), 64'd0);
        idle();
        check("R1 all answers seen", 64'(q_mask.size()), 64'd0);

        // R11/R12 reset clears the error and stacks
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 err cleared by reset", 64'(err), 64'd0);
        check("R12 empty after reset", 64'(stk_empty), 64'hF);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule